// File: doc/BRIEF.md
# Load-Use Hazard and Operand Bypass Unit

This unit does dependency checking and operand bypass for a short in-order integer pipeline. In this pipeline, loads and stores form their effective address in decode and present it to data memory in that same cycle. The memory access itself takes place in execute. Arithmetic, multiply and condition-setting instructions all finish in execute. The unit keeps a small record of the instructions in the execute and write-back stages. It compares the decode instruction's source indices against those records. For each source it then picks the newest available copy of the value: the register file, the execute result, the load data returning in execute, or the write-back result.

Only one case needs a pipeline bubble. A load or store in decode may need, as an address operand, the register that a load in execute is still fetching. That value arrives too late for the address adder in the same cycle. For this case the unit raises `stall` for exactly one cycle, and the surrounding pipeline holds the decode instruction. The unit puts a no-op into execute, and the held instruction then picks up the value from write-back. An arithmetic or multiply consumer of the load, or a store that uses the loaded value as its data, gets the load data directly with no bubble. Condition codes are forwarded by the same rules, using execute first and then write-back.

Top module: `hzd_fwd_unit`

## Requirements
- R1: When no valid, register-writing instruction in execute or write-back targets a source index, that source selects the register file (select code 0) and carries the register-file value.
- R2: When the instruction in execute is an ALU (class 0) or multiply (class 1) instruction that writes the source register, the source selects the execute result (code 1) without stalling.
- R3: When a load (class 2) in execute writes a register used by an ALU or multiply operand, or by the data operand of a store (class 3), that source selects the returning load data (code 2) and `stall` stays low.
- R4: `stall` is high exactly when a valid load or store in decode needs a load in execute's destination as its base (`id_ra`) or, with `id_uses_rb` set, as its index (`id_rb`).
- R5: The cycle after `stall`, execute holds a no-op (`ex_nop` high) and `stall` is low again; the held instruction then takes the load value from write-back (code 3).
- R6: When only the write-back stage writes a source register, that source selects the write-back result (code 3).
- R7: When execute and write-back both write the same source register, the execute copy wins.
- R8: For a load or store with base index 0, the base operand is a literal zero: value 0, select code 0, and no dependency or stall, even if an older instruction writes register 0.
- R9: A producer that does not write a register, or a stage that holds a no-op, never supplies a bypass.
- R10: When `id_rd_cc` is set, the condition value comes from execute (code 1) if execute sets conditions, else from write-back (code 3) if that stage sets them, else from the architected flags (code 0).
- R11: A load or store whose index operand is unused (`id_uses_rb` low) does not stall on a match of `id_rb` against a load in execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | Decode holds a valid instruction |
| id_cls | input | 2 | Class: 0 ALU, 1 multiply, 2 load, 3 store |
| id_ra | input | REG_W | Base / first source index |
| id_rb | input | REG_W | Index / second source index |
| id_rs | input | REG_W | Store data source index |
| id_rd | input | REG_W | Destination index |
| id_wr | input | 1 | Instruction writes `id_rd` |
| id_uses_rb | input | 1 | Second source is used |
| id_rd_cc | input | 1 | Instruction reads condition flags |
| id_set_cc | input | 1 | Instruction sets condition flags |
| rf_a | input | DATA_W | Register-file value for `id_ra` |
| rf_b | input | DATA_W | Register-file value for `id_rb` |
| rf_s | input | DATA_W | Register-file value for `id_rs` |
| ex_result | input | DATA_W | ALU/multiply result in execute |
| ld_data | input | DATA_W | Load data returning in execute |
| wb_result | input | DATA_W | Result in write-back |
| ex_cc | input | CC_W | Flags produced in execute |
| wb_cc | input | CC_W | Flags in write-back |
| arch_cc | input | CC_W | Architected flags |
| stall | output | 1 | Hold decode, bubble into execute |
| ex_nop | output | 1 | Execute holds a no-op |
| sel_a | output | 2 | Source select for `id_ra` |
| sel_b | output | 2 | Source select for `id_rb` |
| sel_s | output | 2 | Source select for `id_rs` |
| opnd_a | output | DATA_W | Bypassed value for `id_ra` |
| opnd_b | output | DATA_W | Bypassed value for `id_rb` |
| opnd_s | output | DATA_W | Bypassed value for `id_rs` |
| cc_sel | output | 2 | Condition source select |
| cc_val | output | CC_W | Bypassed condition value |

## Verification
The selects, operand values, condition value and `stall` are combinational in the decode inputs and the stage records. They are therefore due in the same cycle the stimulus is driven, and the bench samples them 2 ns after the falling edge, before the next rising edge. `ex_nop` and every hazard caused by a just-issued instruction show up one rising edge later. After each rising edge the bench updates its own record of the execute and write-back stages, and computes the next item's expectation from that record. A stalled item is re-presented on the following cycle with its own expectation, which covers the one-cycle bubble and the write-back pickup.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

   typedef enum logic [1:0] {
      CLS_ALU   = 2'd0,
      CLS_MUL   = 2'd1,
      CLS_LOAD  = 2'd2,
      CLS_STORE = 2'd3
   } icls_e;

   typedef enum logic [1:0] {
      SEL_RF = 2'd0,
      SEL_EX = 2'd1,
      SEL_LD = 2'd2,
      SEL_WB = 2'd3
   } osel_e;

   function automatic logic cls_is_mem(input icls_e c);
      return (c == CLS_LOAD) || (c == CLS_STORE);
   endfunction

endpackage

// File: rtl/hzd_stage_track.sv
module hzd_stage_track #(
   parameter int REG_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             id_ld,
   input  logic             id_wr,
   input  logic             id_setcc,
   input  logic [REG_W-1:0] id_rd,
   output logic             ex_v,
   output logic             ex_ld,
   output logic             ex_wr,
   output logic             ex_setcc,
   output logic [REG_W-1:0] ex_rd,
   output logic             wb_v,
   output logic             wb_wr,
   output logic             wb_setcc,
   output logic [REG_W-1:0] wb_rd
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ex_v     <= 1'b0;
         ex_ld    <= 1'b0;
         ex_wr    <= 1'b0;
         ex_setcc <= 1'b0;
         ex_rd    <= '0;
         wb_v     <= 1'b0;
         wb_wr    <= 1'b0;
         wb_setcc <= 1'b0;
         wb_rd    <= '0;
      end else begin
         wb_v     <= ex_v;
         wb_wr    <= ex_wr;
         wb_setcc <= ex_setcc;
         wb_rd    <= ex_rd;
         if (adv) begin
            ex_v     <= 1'b1;
            ex_ld    <= id_ld;
            ex_wr    <= id_wr;
            ex_setcc <= id_setcc;
            ex_rd    <= id_rd;
         end else begin
            // bubble: execute receives a no-op
            ex_v     <= 1'b0;
            ex_ld    <= 1'b0;
            ex_wr    <= 1'b0;
            ex_setcc <= 1'b0;
            ex_rd    <= '0;
         end
      end
   end

endmodule

// File: rtl/hzd_src_fwd.sv
module hzd_src_fwd
   import hzd_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int REG_W  = 5
) (
   input  logic [REG_W-1:0]  idx,
   input  logic              lit0,
   input  logic              ex_v,
   input  logic              ex_ld,
   input  logic              ex_wr,
   input  logic [REG_W-1:0]  ex_rd,
   input  logic              wb_v,
   input  logic              wb_wr,
   input  logic [REG_W-1:0]  wb_rd,
   input  logic [DATA_W-1:0] rf_data,
   input  logic [DATA_W-1:0] ex_result,
   input  logic [DATA_W-1:0] ld_data,
   input  logic [DATA_W-1:0] wb_result,
   output osel_e             sel,
   output logic [DATA_W-1:0] val,
   output logic              ld_hit
);

   logic ex_hit, wb_hit;

   assign ex_hit = ex_v && ex_wr && (ex_rd == idx) && !lit0;
   assign wb_hit = wb_v && wb_wr && (wb_rd == idx) && !lit0;
   assign ld_hit = ex_hit && ex_ld;

   // youngest producer first
   always_comb begin
      if (ex_hit)      sel = ex_ld ? SEL_LD : SEL_EX;
      else if (wb_hit) sel = SEL_WB;
      else             sel = SEL_RF;
   end

   always_comb begin
      unique case (sel)
         SEL_EX:  val = ex_result;
         SEL_LD:  val = ld_data;
         SEL_WB:  val = wb_result;
         default: val = lit0 ? '0 : rf_data;
      endcase
   end

endmodule

// File: rtl/hzd_stall_ctl.sv
module hzd_stall_ctl
   import hzd_pkg::*;
(
   input  logic  id_valid,
   input  icls_e id_cls,
   input  logic  id_uses_rb,
   input  logic  ld_hit_a,
   input  logic  ld_hit_b,
   output logic  stall
);

   logic addr_dep;

   assign addr_dep = ld_hit_a || (id_uses_rb && ld_hit_b);
   assign stall    = id_valid && cls_is_mem(id_cls) && addr_dep;

endmodule

// File: rtl/hzd_cc_fwd.sv
module hzd_cc_fwd
   import hzd_pkg::*;
#(
   parameter int CC_W = 4
) (
   input  logic            rd_cc,
   input  logic            ex_v,
   input  logic            ex_setcc,
   input  logic            wb_v,
   input  logic            wb_setcc,
   input  logic [CC_W-1:0] ex_cc,
   input  logic [CC_W-1:0] wb_cc,
   input  logic [CC_W-1:0] arch_cc,
   output osel_e           cc_sel,
   output logic [CC_W-1:0] cc_val
);

   always_comb begin
      if (rd_cc && ex_v && ex_setcc) begin
         cc_sel = SEL_EX;
         cc_val = ex_cc;
      end else if (rd_cc && wb_v && wb_setcc) begin
         cc_sel = SEL_WB;
         cc_val = wb_cc;
      end else begin
         cc_sel = SEL_RF;
         cc_val = arch_cc;
      end
   end

endmodule

// File: rtl/hzd_fwd_unit.sv
module hzd_fwd_unit
   import hzd_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int REG_W     = 5,
   parameter int CC_W      = 4,
   parameter bit ZERO_BASE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              id_valid,
   input  logic [1:0]        id_cls,
   input  logic [REG_W-1:0]  id_ra,
   input  logic [REG_W-1:0]  id_rb,
   input  logic [REG_W-1:0]  id_rs,
   input  logic [REG_W-1:0]  id_rd,
   input  logic              id_wr,
   input  logic              id_uses_rb,
   input  logic              id_rd_cc,
   input  logic              id_set_cc,
   input  logic [DATA_W-1:0] rf_a,
   input  logic [DATA_W-1:0] rf_b,
   input  logic [DATA_W-1:0] rf_s,
   input  logic [DATA_W-1:0] ex_result,
   input  logic [DATA_W-1:0] ld_data,
   input  logic [DATA_W-1:0] wb_result,
   input  logic [CC_W-1:0]   ex_cc,
   input  logic [CC_W-1:0]   wb_cc,
   input  logic [CC_W-1:0]   arch_cc,
   output logic              stall,
   output logic              ex_nop,
   output logic [1:0]        sel_a,
   output logic [1:0]        sel_b,
   output logic [1:0]        sel_s,
   output logic [DATA_W-1:0] opnd_a,
   output logic [DATA_W-1:0] opnd_b,
   output logic [DATA_W-1:0] opnd_s,
   output logic [1:0]        cc_sel,
   output logic [CC_W-1:0]   cc_val
);

   localparam int NUM_SRC = 3;

   if (DATA_W < 1) begin : g_bad_data_w
      $error("hzd_fwd_unit: DATA_W must be at least 1");
   end
   if (REG_W < 1 || REG_W > 8) begin : g_bad_reg_w
      $error("hzd_fwd_unit: REG_W must be 1..8");
   end
   if (CC_W < 1) begin : g_bad_cc_w
      $error("hzd_fwd_unit: CC_W must be at least 1");
   end

   icls_e cls;
   logic  is_mem;
   logic  adv;

   assign cls    = icls_e'(id_cls);
   assign is_mem = cls_is_mem(cls);

   // stage records
   logic             ex_v, ex_ld, ex_wr, ex_setcc;
   logic [REG_W-1:0] ex_rd;
   logic             wb_v, wb_wr, wb_setcc;
   logic [REG_W-1:0] wb_rd;

   hzd_stage_track #(.REG_W(REG_W)) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (adv),
      .id_ld    (cls == CLS_LOAD),
      .id_wr    (id_wr),
      .id_setcc (id_set_cc),
      .id_rd    (id_rd),
      .ex_v     (ex_v),
      .ex_ld    (ex_ld),
      .ex_wr    (ex_wr),
      .ex_setcc (ex_setcc),
      .ex_rd    (ex_rd),
      .wb_v     (wb_v),
      .wb_wr    (wb_wr),
      .wb_setcc (wb_setcc),
      .wb_rd    (wb_rd)
   );

   // per-source bypass
   logic [REG_W-1:0]  src_idx [NUM_SRC];
   logic [DATA_W-1:0] src_rf  [NUM_SRC];
   logic              src_lit [NUM_SRC];
   osel_e             src_sel [NUM_SRC];
   logic [DATA_W-1:0] src_val [NUM_SRC];
   logic              src_ldh [NUM_SRC];

   assign src_idx[0] = id_ra;
   assign src_idx[1] = id_rb;
   assign src_idx[2] = id_rs;
   assign src_rf[0]  = rf_a;
   assign src_rf[1]  = rf_b;
   assign src_rf[2]  = rf_s;

   // only the base of a memory access can read register 0 as literal zero
   if (ZERO_BASE) begin : g_zero_base
      assign src_lit[0] = is_mem && (id_ra == '0);
   end else begin : g_plain_base
      assign src_lit[0] = 1'b0;
   end
   assign src_lit[1] = 1'b0;
   assign src_lit[2] = 1'b0;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      hzd_src_fwd #(.DATA_W(DATA_W), .REG_W(REG_W)) u_src (
         .idx       (src_idx[i]),
         .lit0      (src_lit[i]),
         .ex_v      (ex_v),
         .ex_ld     (ex_ld),
         .ex_wr     (ex_wr),
         .ex_rd     (ex_rd),
         .wb_v      (wb_v),
         .wb_wr     (wb_wr),
         .wb_rd     (wb_rd),
         .rf_data   (src_rf[i]),
         .ex_result (ex_result),
         .ld_data   (ld_data),
         .wb_result (wb_result),
         .sel       (src_sel[i]),
         .val       (src_val[i]),
         .ld_hit    (src_ldh[i])
      );
   end

   // the store-data hit never stalls: it is bypassed in execute
   logic unused_s_ldh;
   assign unused_s_ldh = src_ldh[2];

   hzd_stall_ctl u_stall (
      .id_valid   (id_valid),
      .id_cls     (cls),
      .id_uses_rb (id_uses_rb),
      .ld_hit_a   (src_ldh[0]),
      .ld_hit_b   (src_ldh[1]),
      .stall      (stall)
   );

   assign adv = id_valid && !stall;

   osel_e cc_sel_e;

   hzd_cc_fwd #(.CC_W(CC_W)) u_cc (
      .rd_cc    (id_rd_cc),
      .ex_v     (ex_v),
      .ex_setcc (ex_setcc),
      .wb_v     (wb_v),
      .wb_setcc (wb_setcc),
      .ex_cc    (ex_cc),
      .wb_cc    (wb_cc),
      .arch_cc  (arch_cc),
      .cc_sel   (cc_sel_e),
      .cc_val   (cc_val)
   );

   assign ex_nop = !ex_v;
   assign sel_a  = src_sel[0];
   assign sel_b  = src_sel[1];
   assign sel_s  = src_sel[2];
   assign opnd_a = src_val[0];
   assign opnd_b = src_val[1];
   assign opnd_s = src_val[2];
   assign cc_sel = cc_sel_e;

endmodule

// File: rtl/hzd_fwd_chk.sv
module hzd_fwd_chk #(
   parameter int DATA_W    = 32,
   parameter int REG_W     = 5,
   parameter bit ZERO_BASE = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              id_valid,
   input logic [1:0]        id_cls,
   input logic [REG_W-1:0]  id_ra,
   input logic [REG_W-1:0]  id_rb,
   input logic              id_uses_rb,
   input logic              stall,
   input logic              ex_nop,
   input logic [1:0]        sel_a,
   input logic [DATA_W-1:0] opnd_a,
   input logic              ex_v,
   input logic              ex_ld,
   input logic              ex_wr,
   input logic [REG_W-1:0]  ex_rd,
   input logic              wb_v,
   input logic              wb_wr,
   input logic [REG_W-1:0]  wb_rd
);

   logic base_lit;
   assign base_lit = ZERO_BASE && id_cls[1] && (id_ra == '0);

   p_stall_mem_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (id_valid && id_cls[1]));

   p_no_alu_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (id_valid && !id_cls[1]) |-> !stall);

   p_stall_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> !stall);

   p_bubble_after_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> ex_nop);

   p_ex_over_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_v && ex_wr && wb_v && wb_wr && ex_rd == wb_rd && id_ra == ex_rd && !base_lit)
      |-> (sel_a != 2'd3));

   p_zero_base_r8: assert property (@(posedge clk) disable iff (!rst_n)
      base_lit |-> (opnd_a == '0 && sel_a == 2'd0));

   p_index_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && !(ex_ld && ex_rd == id_ra && !base_lit)) |-> (id_uses_rb && id_rb == ex_rd));

endmodule

bind hzd_fwd_unit hzd_fwd_chk #(
   .DATA_W    (DATA_W),
   .REG_W     (REG_W),
   .ZERO_BASE (ZERO_BASE)
) u_chk (.*);

// File: tb/test_hzd_fwd_unit.sv
module test_hzd_fwd_unit;

   localparam int DW = 32;
   localparam int RW = 5;
   localparam int CW = 4;

   localparam logic [DW-1:0] RFA = 32'h1111_1111;
   localparam logic [DW-1:0] RFB = 32'h2222_2222;
   localparam logic [DW-1:0] RFS = 32'h3333_3333;
   localparam logic [DW-1:0] EXV = 32'hE0E0_0001;
   localparam logic [DW-1:0] LDV = 32'h1D1D_0002;
   localparam logic [DW-1:0] WBV = 32'hB0B0_0003;
   localparam logic [CW-1:0] EXC = 4'h5;
   localparam logic [CW-1:0] WBC = 4'hA;
   localparam logic [CW-1:0] ARC = 4'h3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          id_valid = 1'b0;
   logic [1:0]    id_cls = 2'd0;
   logic [RW-1:0] id_ra = '0, id_rb = '0, id_rs = '0, id_rd = '0;
   logic          id_wr = 1'b0, id_uses_rb = 1'b0, id_rd_cc = 1'b0, id_set_cc = 1'b0;
   logic          stall, ex_nop;
   logic [1:0]    sel_a, sel_b, sel_s, cc_sel;
   logic [DW-1:0] opnd_a, opnd_b, opnd_s;
   logic [CW-1:0] cc_val;

   always #5 clk = ~clk;

   hzd_fwd_unit #(.DATA_W(DW), .REG_W(RW), .CC_W(CW), .ZERO_BASE(1'b1)) i_hzd_fwd_unit (
      .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_cls(id_cls),
      .id_ra(id_ra), .id_rb(id_rb), .id_rs(id_rs), .id_rd(id_rd), .id_wr(id_wr),
      .id_uses_rb(id_uses_rb), .id_rd_cc(id_rd_cc), .id_set_cc(id_set_cc),
      .rf_a(RFA), .rf_b(RFB), .rf_s(RFS), .ex_result(EXV), .ld_data(LDV),
      .wb_result(WBV), .ex_cc(EXC), .wb_cc(WBC), .arch_cc(ARC),
      .stall(stall), .ex_nop(ex_nop), .sel_a(sel_a), .sel_b(sel_b), .sel_s(sel_s),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_s(opnd_s), .cc_sel(cc_sel), .cc_val(cc_val)
   );

   typedef struct {
      string         tag;
      logic          stall;
      logic          nop;
      logic [1:0]    sa, sb, ss, sc;
      logic [DW-1:0] va, vb, vs;
      logic [CW-1:0] vc;
   } item_t;

   item_t sb_q[$];
   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // bench record of the later stages
   bit            m_ex_v = 0, m_ex_ld = 0, m_ex_wr = 0, m_ex_cc = 0;
   logic [RW-1:0] m_ex_rd = '0;
   bit            m_wb_v = 0, m_wb_wr = 0, m_wb_cc = 0;
   logic [RW-1:0] m_wb_rd = '0;

   function automatic logic [1:0] pick(input logic [RW-1:0] idx, input bit lit);
      if (lit) return 2'd0;                                   // R8
      if (m_ex_v && m_ex_wr && m_ex_rd == idx) return m_ex_ld ? 2'd2 : 2'd1;  // R2 R3 R7
      if (m_wb_v && m_wb_wr && m_wb_rd == idx) return 2'd3;   // R6
      return 2'd0;                                            // R1 R9
   endfunction

   function automatic logic [DW-1:0] valof(input logic [1:0] s, input logic [DW-1:0] rf, input bit lit);
      case (s)
         2'd1: return EXV;
         2'd2: return LDV;
         2'd3: return WBV;
         default: return lit ? '0 : rf;
      endcase
   endfunction

   task automatic issue(input string tag, input logic [1:0] cls, input logic [RW-1:0] ra,
                        input logic [RW-1:0] rb, input logic [RW-1:0] rs, input logic [RW-1:0] rd,
                        input bit wr, input bit urb, input bit rdcc, input bit setcc);
      bit st;
      string t;
      t = tag;
      do begin
         item_t it;
         bit mem, lit;
         @(negedge clk);
         id_valid = 1'b1; id_cls = cls; id_ra = ra; id_rb = rb; id_rs = rs; id_rd = rd;
         id_wr = wr; id_uses_rb = urb; id_rd_cc = rdcc; id_set_cc = setcc;
         mem = cls[1];
         lit = mem && (ra == '0);
         it.tag = t;
         it.sa = pick(ra, lit);
         it.sb = pick(rb, 1'b0);
         it.ss = pick(rs, 1'b0);
         it.va = valof(it.sa, RFA, lit);
         it.vb = valof(it.sb, RFB, 1'b0);
         it.vs = valof(it.ss, RFS, 1'b0);
         st = mem && m_ex_v && m_ex_ld && m_ex_wr &&
              ((!lit && ra == m_ex_rd) || (urb && rb == m_ex_rd));   // R4 R11
         it.stall = st;
         it.nop = !m_ex_v;
         if (rdcc && m_ex_v && m_ex_cc)      begin it.sc = 2'd1; it.vc = EXC; end  // R10
         else if (rdcc && m_wb_v && m_wb_cc) begin it.sc = 2'd3; it.vc = WBC; end
         else                                begin it.sc = 2'd0; it.vc = ARC; end
         sb_q.push_back(it);
         @(posedge clk); #1;
         m_wb_v = m_ex_v; m_wb_wr = m_ex_wr; m_wb_cc = m_ex_cc; m_wb_rd = m_ex_rd;
         if (st) begin
            m_ex_v = 0; m_ex_ld = 0; m_ex_wr = 0; m_ex_cc = 0; m_ex_rd = '0;
            t = {tag, " R5 held"};
         end else begin
            m_ex_v = 1; m_ex_ld = (cls == 2'd2); m_ex_wr = wr; m_ex_cc = setcc; m_ex_rd = rd;
         end
      end while (st);
   endtask

   task automatic idle();
      @(negedge clk);
      id_valid = 1'b0; id_wr = 1'b0; id_rd_cc = 1'b0; id_set_cc = 1'b0;
      @(posedge clk); #1;
      m_wb_v = m_ex_v; m_wb_wr = m_ex_wr; m_wb_cc = m_ex_cc; m_wb_rd = m_ex_rd;
      m_ex_v = 0; m_ex_ld = 0; m_ex_wr = 0; m_ex_cc = 0; m_ex_rd = '0;
   endtask

   // monitor: compares each expected item in its own cycle
   initial begin
      forever begin
         @(negedge clk); #2;
         if (sb_q.size() > 0) begin
            item_t e;
            e = sb_q.pop_front();
            n_chk++;
            if (stall !== e.stall || ex_nop !== e.nop || sel_a !== e.sa || sel_b !== e.sb ||
                sel_s !== e.ss || opnd_a !== e.va || opnd_b !== e.vb || opnd_s !== e.vs ||
                cc_sel !== e.sc || cc_val !== e.vc) begin
               n_bad++;
               $display("FAIL %s: got stall=%0b nop=%0b sel=%0d/%0d/%0d a=%h b=%h s=%h cc=%0d:%h exp stall=%0b nop=%0b sel=%0d/%0d/%0d a=%h b=%h s=%h cc=%0d:%h",
                        e.tag, stall, ex_nop, sel_a, sel_b, sel_s, opnd_a, opnd_b, opnd_s, cc_sel, cc_val,
                        e.stall, e.nop, e.sa, e.sb, e.ss, e.va, e.vb, e.vs, e.sc, e.vc);
            end
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      n_chk++;
      if (stall !== 1'b0 || ex_nop !== 1'b1) begin
         n_bad++;
         $display("FAIL reset R5: stall=%0b ex_nop=%0b exp stall=0 ex_nop=1", stall, ex_nop);
      end
      //      tag                 cls   ra  rb  rs  rd  wr urb rcc scc
      issue("R1 no deps",        2'd0, 1,  2,  0,  3,  1, 1, 0, 0);
      issue("R2 alu to alu",     2'd0, 3,  4,  0,  5,  1, 1, 0, 0);
      issue("R2 R6 mul",         2'd1, 5,  3,  0,  6,  1, 1, 0, 0);
      issue("R2 load base",      2'd2, 6,  0,  0,  7,  1, 0, 0, 0);
      issue("R3 alu of load",    2'd0, 7,  7,  0,  8,  1, 1, 0, 0);
      issue("R2 load base alu",  2'd2, 8,  0,  0,  9,  1, 0, 0, 0);
      issue("R3 R11 store data", 2'd3, 10, 9,  9,  9,  0, 0, 0, 0);
      issue("R9 R6 no-write ex", 2'd0, 9,  1,  0,  12, 1, 1, 0, 0);
      issue("R2 load",           2'd2, 12, 0,  0,  13, 1, 0, 0, 0);
      issue("R4 base on load",   2'd2, 13, 0,  0,  14, 1, 0, 0, 0);
      issue("R4 R8 index load",  2'd3, 0,  14, 14, 0,  0, 1, 0, 0);
      issue("R7 first",          2'd0, 1,  2,  0,  20, 1, 1, 0, 0);
      issue("R7 second",         2'd1, 1,  2,  0,  20, 1, 1, 0, 0);
      issue("R7 youngest",       2'd0, 20, 20, 20, 21, 1, 1, 0, 0);
      issue("R8 load to r0",     2'd2, 1,  0,  0,  0,  1, 0, 0, 0);
      issue("R8 base r0",        2'd2, 0,  0,  0,  22, 1, 0, 0, 0);
      issue("R10 set cc",        2'd0, 1,  2,  0,  23, 1, 1, 0, 1);
      issue("R10 cc from ex",    2'd0, 1,  2,  0,  24, 1, 1, 1, 0);
      issue("R10 cc from wb",    2'd0, 1,  2,  0,  25, 1, 1, 1, 0);
      idle();
      idle();
      issue("R10 R9 cc arch",    2'd0, 25, 2,  0,  26, 1, 1, 1, 0);
      @(negedge clk); id_valid = 1'b0;
      repeat (3) @(negedge clk);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, got timeout exp completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule